// File: doc/BRIEF.md
# Eight-Bit Accumulator Processor Core

A small multi-cycle processor for control tasks inside a larger chip. Its data path is 8 bits wide and it addresses 64K bytes through a 16-bit address. The programmer sees three items: an 8-bit accumulator, one 8-bit scratch register and a single zero flag. The core fetches one opcode byte at a time and steps through a fetch, decode and execute sequence. Instructions that name a memory location or a jump target carry a 16-bit address in the two bytes that follow the opcode, low byte first.

The memory port is a fixed-latency, single-master port with a read strobe and a write strobe. It has no back-pressure: the memory answers every read strobe with data on the read-data input in the next cycle, and it takes every write in the cycle of its strobe. The port carries no valid/ready pair, because no stream of data crosses it. Each instruction takes a fixed number of cycles. One-byte instructions take 3 cycles, jumps take 5, stores 6 and loads 7.

Top module: `acc8_core`

## Requirements
- R1: A synchronous reset clears the program counter, accumulator, scratch register and zero flag to zero. The first cycle after reset issues a read strobe at address 0x0000.
- R2: Read data is taken exactly one cycle after the read strobe. The read and write strobes are never active together.
- R3: Opcodes 0x01, 0x02, 0x05, 0x06 and 0x07 are followed by a 16-bit address, low byte first. All other opcodes are one byte long. The program counter advances by one for every byte fetched.
- R4: Opcode 0x01 loads the accumulator from the operand address. Opcode 0x02 writes the accumulator to the operand address, and the full 16 bits appear on the address port.
- R5: Opcode 0x03 copies the accumulator into the scratch register. Opcode 0x04 copies the scratch register into the accumulator.
- R6: Opcode 0x05 loads the program counter with the operand address.
- R7: Opcode 0x06 jumps only when the zero flag is 1, and opcode 0x07 jumps only when it is 0. A jump that is not taken continues at the byte after the two operand bytes.
- R8: With A the accumulator and S the scratch register: 0x08 gives A+S, 0x09 gives A-S, 0x0A gives A+1, 0x0B gives 0, 0x0C gives A AND S, 0x0D gives A OR S, 0x0E gives A XOR S and 0x0F gives NOT A. Sums and differences wrap modulo 256, and the result goes to the accumulator.
- R9: Opcodes 0x08 to 0x0F set the zero flag to 1 when their result is zero and to 0 otherwise. No other instruction changes the flag.
- R10: Opcode 0x00 and every opcode from 0x10 to 0xFF change no programmer-visible state other than moving the program counter past the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data (accumulator) |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the read strobe |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |

## Verification
The assertions check the following on every cycle: the strobes never overlap, each read is followed by a state that takes its data, the program counter steps after each fetch, an unconditional jump lands on the assembled operand, and the zero flag and unknown opcodes leave state alone. Only the bench's scenarios can show that arithmetic results are correct. The same holds for the choice between taken and not-taken conditional jumps and for stores reaching a full 16-bit address. The bench runs random short programs that store their result and encode the final flag through the branch path they take.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_EXEC, S_OPLO, S_OPHI, S_OPEND, S_MEM, S_LDWAIT
  } state_t;

  localparam logic [7:0] OPC_LOAD    = 8'h01;
  localparam logic [7:0] OPC_STORE   = 8'h02;
  localparam logic [7:0] OPC_TO_R    = 8'h03;
  localparam logic [7:0] OPC_FROM_R  = 8'h04;
  localparam logic [7:0] OPC_GOTO    = 8'h05;
  localparam logic [7:0] OPC_GOTO_Z  = 8'h06;
  localparam logic [7:0] OPC_GOTO_NZ = 8'h07;

  function automatic logic takes_operand(input logic [7:0] op);
    return (op == OPC_LOAD) || (op == OPC_STORE) || (op == OPC_GOTO) ||
           (op == OPC_GOTO_Z) || (op == OPC_GOTO_NZ);
  endfunction
endpackage

// File: rtl/acc8_alu.sv
module acc8_alu #(
  parameter int W = 8
) (
  input  logic [2:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         zero
);
  always_comb begin
    unique case (sel)
      3'd0: res = a + b;
      3'd1: res = a - b;
      3'd2: res = a + W'(1);
      3'd3: res = '0;
      3'd4: res = a & b;
      3'd5: res = a | b;
      3'd6: res = a ^ b;
      default: res = ~a;
    endcase
    zero = ~|res;
  end
endmodule

// File: rtl/acc8_fsm.sv
module acc8_fsm
  import acc8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rdata,
  input  logic [W-1:0] ir,
  output state_t       state
);
  state_t nxt;

  always_comb begin
    nxt = S_FETCH;
    unique case (state)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: nxt = takes_operand(rdata) ? S_OPLO : S_EXEC;
      S_EXEC:   nxt = S_FETCH;
      S_OPLO:   nxt = S_OPHI;
      S_OPHI:   nxt = S_OPEND;
      S_OPEND:  nxt = (ir == OPC_LOAD || ir == OPC_STORE) ? S_MEM : S_FETCH;
      S_MEM:    nxt = (ir == OPC_LOAD) ? S_LDWAIT : S_FETCH;
      default:  nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  // R4: the data access state is reached only by a load or a store
  p_mem_ldst_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_MEM) |-> (ir == OPC_LOAD || ir == OPC_STORE));
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [2*DATA_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  output logic                  mem_rd_o,
  output logic                  mem_wr_o
);
  localparam int ADDR_W = 2 * DATA_W;

  state_t              state;
  logic [ADDR_W-1:0]   pc;
  logic [DATA_W-1:0]   ac, r, ir, lo, hi;
  logic                z;
  logic [DATA_W-1:0]   alu_res;
  logic                alu_zero;
  logic                is_alu, take_jump;

  acc8_fsm #(.W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .rdata(mem_rdata_i), .ir(ir), .state(state)
  );

  acc8_alu #(.W(DATA_W)) u_alu (
    .sel(ir[2:0]), .a(ac), .b(r), .res(alu_res), .zero(alu_zero)
  );

  assign is_alu    = (ir >> 3) == DATA_W'(1);
  assign take_jump = (ir == OPC_GOTO) || (ir == OPC_GOTO_Z && z) ||
                     (ir == OPC_GOTO_NZ && !z);

  always_comb begin
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_addr_o  = pc;
    mem_wdata_o = ac;
    unique case (state)
      S_FETCH, S_OPLO, S_OPHI: mem_rd_o = 1'b1;
      S_MEM: begin
        mem_addr_o = {hi, lo};
        if (ir == OPC_LOAD) mem_rd_o = 1'b1;
        else                mem_wr_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0; ac <= '0; r <= '0; z <= 1'b0;
      ir <= '0; lo <= '0; hi <= '0;
    end else begin
      unique case (state)
        S_FETCH:  pc <= pc + ADDR_W'(1);
        S_DECODE: ir <= mem_rdata_i;
        S_OPLO:   pc <= pc + ADDR_W'(1);
        S_OPHI: begin
          lo <= mem_rdata_i;
          pc <= pc + ADDR_W'(1);
        end
        S_OPEND: begin
          hi <= mem_rdata_i;
          if (take_jump) pc <= {mem_rdata_i, lo};
        end
        S_LDWAIT: ac <= mem_rdata_i;
        S_EXEC: begin
          if (ir == OPC_TO_R)        r  <= ac;
          else if (ir == OPC_FROM_R) ac <= r;
          else if (is_alu) begin
            ac <= alu_res;
            z  <= alu_zero;
          end
        end
        default: ;
      endcase
    end
  end

  // R1: first cycle after reset fetches from address zero
  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_rd_o && mem_addr_o == '0));
  // R2: strobes never overlap
  p_rdwr_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));
  // R2: every read is followed by a state that consumes its data
  p_read_used_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |=> (state == S_DECODE || state == S_OPHI ||
                  state == S_OPEND || state == S_LDWAIT));
  // R3: each opcode fetch steps the program counter by one
  p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (pc == $past(pc) + ADDR_W'(1)));
  // R6: unconditional jump lands on the assembled operand
  p_jump_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_OPEND && ir == OPC_GOTO) |=> (pc == {$past(mem_rdata_i), $past(lo)}));
  // R9: the flag moves only while an arithmetic/logic opcode executes
  p_z_only_alu_r9: assert property (@(posedge clk) disable iff (rst)
    !(state == S_EXEC && is_alu) |=> $stable(z));
  // R10: unknown opcodes leave accumulator, register and flag alone
  p_badop_nop_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && ir >= DATA_W'(8'h10)) |=> ($stable(ac) && $stable(r) && $stable(z)));
endmodule

// File: tb/test_acc8_core.sv
module test_acc8_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i;
  logic        mem_rd_o, mem_wr_o;

  logic [7:0]  mem [0:4095];
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [15:0] last_waddr = '0;
  logic [7:0]  last_wdata = '0;

  int total = 0;
  int failed = 0;

  always #5 clk = ~clk;

  acc8_core i_acc8_core (
    .clk(clk), .rst(rst), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o)
  );

  // behavioural memory: one-cycle read latency, 12 address bits decoded
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr_o) begin
      mem[mem_addr_o[11:0]] <= mem_wdata_o;
      last_waddr <= mem_addr_o;
      last_wdata <= mem_wdata_o;
    end
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[11:0]];
  end

  task automatic poke(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic op3(input logic [11:0] a, input logic [7:0] op, input logic [15:0] t);
    poke(a, op); poke(a + 12'd1, t[7:0]); poke(a + 12'd2, t[15:8]);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  task automatic run(input int cycles);
    @(negedge clk); rst = 1'b0;
    repeat (cycles) @(negedge clk);
    rst = 1'b1;
  endtask

  // reference model of the one-byte instructions: returns {z, acc}
  function automatic logic [8:0] ref_exec(input logic [7:0] op, input logic [7:0] a,
                                          input logic [7:0] s, input logic zin);
    logic [7:0] res;
    res = a;
    case (op)
      8'h04: res = s;
      8'h08: res = a + s;
      8'h09: res = a - s;
      8'h0A: res = a + 8'd1;
      8'h0B: res = 8'd0;
      8'h0C: res = a & s;
      8'h0D: res = a | s;
      8'h0E: res = a ^ s;
      8'h0F: res = ~a;
      default: res = a;
    endcase
    if (op >= 8'h08 && op <= 8'h0F) return {(res == 8'd0), res};
    return {zin, res};
  endfunction

  localparam logic [11:0] A_AT = 12'h800, B_AT = 12'h801, C55 = 12'h802, CAA = 12'h803;
  localparam logic [11:0] OUT_AT = 12'h810, ZOUT_AT = 12'h811;

  initial begin
    repeat (200000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7319);
    poke(C55, 8'h55); poke(CAA, 8'hAA);

    // R1: reset state
    @(negedge clk);
    chk("R1 rd strobe in reset", {15'd0, mem_rd_o}, 16'd1);
    chk("R1 address zero", mem_addr_o, 16'h0000);
    chk("R2 no write in reset", {15'd0, mem_wr_o}, 16'd0);

    // R1/R5/R7: registers clear after reset; Z=0 so JPNZ is taken
    poke(OUT_AT, 8'hEE); poke(ZOUT_AT, 8'hEE);
    poke(12'h000, 8'h04);
    op3(12'h001, 8'h02, 16'h0810);
    op3(12'h004, 8'h07, 16'h0020);
    op3(12'h007, 8'h05, 16'h0007);
    op3(12'h020, 8'h01, 16'h0802);
    op3(12'h023, 8'h02, 16'h0811);
    op3(12'h026, 8'h05, 16'h0026);
    run(60);
    chk("R1 scratch reg clear (via R5 copy)", {8'd0, mem[OUT_AT]}, 16'h0000);
    chk("R7 jump on Z=0 after reset", {8'd0, mem[ZOUT_AT]}, 16'h0055);

    // R4: store to a full 16-bit address
    op3(12'h000, 8'h01, 16'h0802);
    op3(12'h003, 8'h02, 16'hABCD);
    op3(12'h006, 8'h05, 16'h0006);
    run(40);
    chk("R4 store address", last_waddr, 16'hABCD);
    chk("R4 store data", {8'd0, last_wdata}, 16'h0055);

    // R3/R5/R6/R7/R8/R9/R10: short programs, directed first then random
    for (int k = 0; k < 44; k++) begin
      logic [7:0] a, b, op, pre;
      logic z0, use_nz;
      logic [8:0] e;
      logic [7:0] exp_z;
      a = 8'($urandom); b = 8'($urandom);
      case ($urandom % 12)
        0: op = 8'h00; 1: op = 8'h03; 2: op = 8'h04;
        3: op = 8'h10 + 8'($urandom % 240);
        default: op = 8'h08 + 8'($urandom % 8);
      endcase
      pre = ($urandom % 2) ? 8'h0B : 8'h00;
      use_nz = 1'($urandom % 2);
      case (k)
        0: begin op = 8'h09; a = 8'h3C; b = 8'h3C; pre = 8'h00; end
        1: begin op = 8'h0A; b = 8'hFF; end
        2: begin op = 8'h08; a = 8'h80; b = 8'h80; end
        3: begin op = 8'h0B; b = 8'h17; pre = 8'h00; end
        4: begin op = 8'h0F; b = 8'hFF; end
        5: begin op = 8'hFF; pre = 8'h0B; end
        6: begin op = 8'h04; pre = 8'h0B; use_nz = 1'b1; end
        7: begin op = 8'h09; a = 8'h01; b = 8'h00; end
        default: ;
      endcase
      z0 = (pre == 8'h0B);
      e = ref_exec(op, b, a, z0);
      if (use_nz) exp_z = e[8] ? 8'h55 : 8'hAA;
      else        exp_z = e[8] ? 8'hAA : 8'h55;

      poke(A_AT, a); poke(B_AT, b); poke(OUT_AT, 8'hEE); poke(ZOUT_AT, 8'hEE);
      poke(12'h000, pre);
      op3(12'h001, 8'h01, 16'h0800);
      poke(12'h004, 8'h03);
      op3(12'h005, 8'h01, 16'h0801);
      poke(12'h008, op);
      op3(12'h009, 8'h02, 16'h0810);
      op3(12'h00C, use_nz ? 8'h07 : 8'h06, 16'h0019);
      op3(12'h00F, 8'h01, 16'h0802);
      op3(12'h012, 8'h02, 16'h0811);
      op3(12'h015, 8'h05, 16'h001F);
      poke(12'h018, 8'h00);
      op3(12'h019, 8'h01, 16'h0803);
      op3(12'h01C, 8'h02, 16'h0811);
      op3(12'h01F, 8'h05, 16'h001F);
      run(90);
      chk($sformatf("R8 R5 R10 result op=%h", op), {8'd0, mem[OUT_AT]}, {8'd0, e[7:0]});
      chk($sformatf("R9 R7 R3 flag path op=%h nz=%0d", op, use_nz),
          {8'd0, mem[ZOUT_AT]}, {8'd0, exp_z});
    end

    report();
    $finish;
  end
endmodule